// File: doc/BRIEF.md
# Signed Fixed-Point Multiplier with Rescaling and Saturation

This block multiplies two signed fixed-point operands and returns one word in a chosen output format. In its wide mode each 32-bit operand has its own fraction width. The block forms the exact double-width product and shifts it right by the difference between the summed input fraction widths and the output fraction width. It rounds to nearest, half-up, by adding the most significant discarded bit. It then clamps the value to a signed range whose width is a parameter. The default formats are 14 and 29 input fraction bits with 12 output fraction bits, which gives a shift of 31. If both operands are the most negative value, the raw product is nudged down by one before scaling. That case always ends as a saturated positive result.

A second mode takes the low halves of the operands as signed Q15 numbers. It returns their rounded Q15 product, sign-extended to 32 bits. The only product that falls outside the range, -1 times -1, is clamped.

Operands arrive on a valid/ready handshake and the result leaves from one register stage with its own valid/ready pair. An accepted operation produces its result one cycle later. A result that is not taken is held, and new input is refused while it is held.

Top module: `fxm_mul`

## Requirements
- R1: While rst_n is low and after its release, out_valid, out_res and out_ovf are all zero until the first operation is accepted.
- R2: With in_q15 = 0, out_res is the signed product in_a*in_b shifted right arithmetically by SHIFT = A_FRAC + B_FRAC - OUT_FRAC (31 by default), plus bit SHIFT-1 of the product. With the defaults, 1.0 in the first format (0x00004000) times 1.0 in the second (0x20000000) gives 0x00001000.
- R3: With in_q15 = 0 and both operands 0x80000000, out_res is the most positive value of the saturation range (0x7FFFFFFF by default) and out_ovf is 1.
- R4: With in_q15 = 0, a rounded value above 2^(SAT_BITS-1)-1 or below -2^(SAT_BITS-1) is replaced by that bound, sign-extended to 32 bits, and out_ovf is 1. Otherwise out_ovf is 0.
- R5: With in_q15 = 1, only bits [15:0] of each operand are used. out_res is (a16*b16 + 2^14) shifted right arithmetically by 15, sign-extended to 32 bits, and out_ovf is 0. Bits [31:16] of the operands have no effect.
- R6: With in_q15 = 1 and both low halves 0x8000, out_res is 0x00007FFF and out_ovf is 1.
- R7: An operation accepted on a clock edge (in_valid and in_ready both high) gives out_valid = 1 with its result after that edge.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_res and out_ovf do not change. When out_ready returns high, the held result is consumed and a new operation is accepted on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are offered |
| in_ready | output | 1 | Operands can be accepted |
| in_q15 | input | 1 | 1 selects the 16-bit Q15 mode, 0 the wide mode |
| in_a | input | IN_W | First operand |
| in_b | input | IN_W | Second operand |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the held result |
| out_res | output | IN_W | Product in the output format |
| out_ovf | output | 1 | The result was clamped |

## Verification
The assertions assume that the consumer controls out_ready freely. They also assume the source keeps in_valid and the operands steady on its side, with no assumption about operand values, since every 32-bit pair has a defined result. The bound-range check takes SAT_BITS from the design, so it holds for both the full-width instance and the narrowed instance. The stimulus holds in_valid for exactly one accepted edge per operation, and it lowers out_ready only in the directed backpressure sequence. In that sequence a second operation waits on a refused handshake until the held result drains.

// File: rtl/fxm_pkg.sv
package fxm_pkg;

  typedef enum logic {
    FXM_WIDE = 1'b0,
    FXM_Q15  = 1'b1
  } fxm_mode_e;

  // Q15 product, rounded half-up and scaled down by 15 (full 33-bit view).
  function automatic logic signed [32:0] fxm_q15_scaled(input logic signed [15:0] a,
                                                        input logic signed [15:0] b);
    logic signed [31:0] prod;
    logic signed [32:0] biased;
    prod   = a * b;
    biased = 33'(prod) + 33'sd16384;
    return biased >>> 15;
  endfunction

endpackage

// File: rtl/fxm_wide_path.sv
module fxm_wide_path #(
  parameter int IN_W     = 32,
  parameter int SHIFT    = 31,
  parameter int SAT_BITS = 32
) (
  input  logic [IN_W-1:0] op_a,
  input  logic [IN_W-1:0] op_b,
  output logic [IN_W-1:0] res,
  output logic            ovf,
  output logic            corner_hit
);
  localparam int PW = 2 * IN_W;
  localparam int RW = PW + 1;
  localparam logic [PW-1:0] CORNER = {2'b01, {(PW-2){1'b0}}};
  localparam logic signed [RW-1:0] SAT_MAX = {{(RW-SAT_BITS+1){1'b0}}, {(SAT_BITS-1){1'b1}}};
  localparam logic signed [RW-1:0] SAT_MIN = {{(RW-SAT_BITS+1){1'b1}}, {(SAT_BITS-1){1'b0}}};

  logic signed [PW-1:0] a_ext, b_ext, prod, prod_adj, shifted;
  logic                 rnd_bit;
  logic signed [RW-1:0] rounded;
  logic                 over_hi, over_lo;

  // Exact double-width product from sign-extended operands.
  assign a_ext = PW'($signed(op_a));
  assign b_ext = PW'($signed(op_b));
  assign prod  = a_ext * b_ext;

  // Only (-2^(N-1))^2 reaches 2^(2N-2); step it down so the shift stays in range.
  assign corner_hit = (prod == CORNER);
  assign prod_adj   = corner_hit ? (prod - PW'(1)) : prod;

  assign shifted = prod_adj >>> SHIFT;

  generate
    if (SHIFT > 0) begin : g_round
      assign rnd_bit = prod_adj[SHIFT-1];
    end else begin : g_noround
      assign rnd_bit = 1'b0;
    end
  endgenerate

  assign rounded = RW'(shifted) + {{(RW-1){1'b0}}, rnd_bit};

  assign over_hi = (rounded > SAT_MAX);
  assign over_lo = (rounded < SAT_MIN);
  assign ovf     = over_hi | over_lo;

  always_comb begin
    if (over_hi)      res = SAT_MAX[IN_W-1:0];
    else if (over_lo) res = SAT_MIN[IN_W-1:0];
    else              res = rounded[IN_W-1:0];
  end

endmodule

// File: rtl/fxm_q15_path.sv
module fxm_q15_path #(
  parameter int OUT_W = 32
) (
  input  logic [15:0]      op_a,
  input  logic [15:0]      op_b,
  output logic [OUT_W-1:0] res,
  output logic             ovf
);
  import fxm_pkg::*;

  logic signed [32:0] scaled;
  logic signed [15:0] res16;

  assign scaled = fxm_q15_scaled($signed(op_a), $signed(op_b));
  assign ovf    = (scaled > 33'sd32767);
  assign res16  = ovf ? 16'sh7FFF : scaled[15:0];
  assign res    = OUT_W'(res16);

endmodule

// File: rtl/fxm_out_stage.sv
module fxm_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         drain,
  input  logic [W-1:0] d_res,
  input  logic         d_ovf,
  input  logic         d_q15,
  output logic         q_valid,
  output logic [W-1:0] q_res,
  output logic         q_ovf,
  output logic         q_q15
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_res   <= '0;
      q_ovf   <= 1'b0;
      q_q15   <= 1'b0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_res   <= d_res;
      q_ovf   <= d_ovf;
      q_q15   <= d_q15;
    end else if (drain) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fxm_mul.sv
module fxm_mul #(
  parameter int IN_W     = 32,
  parameter int A_FRAC   = 14,
  parameter int B_FRAC   = 29,
  parameter int OUT_FRAC = 12,
  parameter int SAT_BITS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_q15,
  input  logic [IN_W-1:0] in_a,
  input  logic [IN_W-1:0] in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [IN_W-1:0] out_res,
  output logic            out_ovf
);
  import fxm_pkg::*;

  localparam int SHIFT = A_FRAC + B_FRAC - OUT_FRAC;

  logic            accept;
  logic            corner_hit;
  logic            q15_q;
  fxm_mode_e       mode;
  logic [IN_W-1:0] wide_res, q15_res, sel_res;
  logic            wide_ovf, q15_ovf, sel_ovf;

  assign mode     = fxm_mode_e'(in_q15);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  fxm_wide_path #(
    .IN_W(IN_W), .SHIFT(SHIFT), .SAT_BITS(SAT_BITS)
  ) u_wide (
    .op_a(in_a), .op_b(in_b), .res(wide_res), .ovf(wide_ovf), .corner_hit(corner_hit)
  );

  fxm_q15_path #(
    .OUT_W(IN_W)
  ) u_q15 (
    .op_a(in_a[15:0]), .op_b(in_b[15:0]), .res(q15_res), .ovf(q15_ovf)
  );

  always_comb begin
    if (mode == FXM_Q15) begin
      sel_res = q15_res;
      sel_ovf = q15_ovf;
    end else begin
      sel_res = wide_res;
      sel_ovf = wide_ovf;
    end
  end

  fxm_out_stage #(
    .W(IN_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .load(accept), .drain(out_ready),
    .d_res(sel_res), .d_ovf(sel_ovf), .d_q15(in_q15),
    .q_valid(out_valid), .q_res(out_res), .q_ovf(out_ovf), .q_q15(q15_q)
  );

endmodule

// File: rtl/fxm_mul_chk.sv
module fxm_mul_chk #(
  parameter int W        = 32,
  parameter int SAT_BITS = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_q15,
  input logic         accept,
  input logic         corner_hit,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_res,
  input logic         out_ovf,
  input logic         q15_q
);
  localparam logic [W-1:0] BND_MAX = {{(W-SAT_BITS+1){1'b0}}, {(SAT_BITS-1){1'b1}}};
  localparam logic [W-1:0] BND_MIN = {{(W-SAT_BITS+1){1'b1}}, {(SAT_BITS-1){1'b0}}};

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_ovf));

  // R8
  refuse_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R3
  corner_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_q15 && corner_hit |=> out_ovf && out_res == BND_MAX);

  // R4
  wide_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf && !q15_q |-> (out_res == BND_MAX || out_res == BND_MIN));

  // R5
  q15_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q15_q |-> (out_res[W-1:15] == '0 || out_res[W-1:15] == '1));

  // R6
  q15_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q15_q && out_ovf |-> out_res == W'(32'h0000_7FFF));

endmodule

bind fxm_mul fxm_mul_chk #(
  .W(IN_W), .SAT_BITS(SAT_BITS)
) u_fxm_mul_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_q15(in_q15), .accept(accept), .corner_hit(corner_hit),
  .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
  .out_ovf(out_ovf), .q15_q(q15_q)
);

// File: tb/fxm_mul_bench.sv
module fxm_mul_bench;
  localparam int NSAT = 20;
  localparam int NV   = 14;
  // {q15, a, b}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'h0000_4000, 32'h2000_0000},
    {1'b0, 32'h0001_8000, 32'hE000_0000},
    {1'b0, 32'h1234_5678, 32'h0ABC_DEF1},
    {1'b0, 32'hFEDC_BA98, 32'h1357_9BDF},
    {1'b0, 32'h0000_0001, 32'h4000_0000},
    {1'b0, 32'hFFFF_FFFF, 32'h4000_0000},
    {1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
    {1'b0, 32'h8000_0000, 32'h7FFF_FFFF},
    {1'b0, 32'h8000_0000, 32'h8000_0000},
    {1'b1, 32'hABCD_4000, 32'h1234_4000},
    {1'b1, 32'h0000_8000, 32'hFFFF_4000},
    {1'b1, 32'h5555_7FFF, 32'h0000_7FFF},
    {1'b1, 32'h0000_0001, 32'h0000_4000},
    {1'b1, 32'h9999_8000, 32'h7777_8000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_q15 = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_ovf;
  logic [31:0] out_res;
  logic        n_in_ready, n_out_valid, n_out_ovf;
  logic [31:0] n_out_res;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fxm_mul u_fxm_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_q15(in_q15), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_ovf(out_ovf)
  );

  fxm_mul #(.SAT_BITS(NSAT)) u_fxm_mul_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(n_in_ready),
    .in_q15(in_q15), .in_a(in_a), .in_b(in_b), .out_valid(n_out_valid),
    .out_ready(out_ready), .out_res(n_out_res), .out_ovf(n_out_ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference built from the requirement text: add half an LSB, then floor.
  task automatic ref_calc(input bit q15, input logic [31:0] a, input logic [31:0] b,
                          input int satb, output logic [31:0] r, output bit o);
    logic signed [127:0] p, t, hi, lo;
    if (q15) begin
      p  = 128'($signed(a[15:0])) * 128'($signed(b[15:0]));
      t  = (p + 128'sd16384) >>> 15;
      hi = 128'sd32767;
      lo = -128'sd32768;
    end else begin
      p  = 128'($signed(a)) * 128'($signed(b));
      t  = (p + (128'sd1 <<< 30)) >>> 31;
      hi = (128'sd1 <<< (satb - 1)) - 128'sd1;
      lo = -(128'sd1 <<< (satb - 1));
    end
    o = 1'b0;
    if (t > hi) begin t = hi; o = 1'b1; end
    if (t < lo) begin t = lo; o = 1'b1; end
    r = t[31:0];
  endtask

  task automatic issue(input bit q15, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_q15 = q15; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] er;
    bit eo;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, out_valid}, 32'h0);
    check("R1 res", out_res, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {31'b0, out_valid}, 32'h0);
    check("R1 ovf after release", {31'b0, out_ovf}, 32'h0);

    // Vector walk: R2, R4, R5 across patterns, both instances
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][64], VEC[i][63:32], VEC[i][31:0]);
      check("R7 valid", {31'b0, out_valid}, 32'h1);
      ref_calc(VEC[i][64], VEC[i][63:32], VEC[i][31:0], 32, er, eo);
      check(VEC[i][64] ? "R5 res" : "R2 res", out_res, er);
      check("R4 ovf", {31'b0, out_ovf}, {31'b0, eo});
      ref_calc(VEC[i][64], VEC[i][63:32], VEC[i][31:0], NSAT, er, eo);
      check("R4 narrow res", n_out_res, er);
      check("R4 narrow ovf", {31'b0, n_out_ovf}, {31'b0, eo});
    end

    // R2: hand-worked values (1.0 x 1.0, rounding at half)
    issue(1'b0, 32'h0000_4000, 32'h2000_0000);
    check("R2 one", out_res, 32'h0000_1000);
    issue(1'b0, 32'h0000_0001, 32'h4000_0000);
    check("R2 half up", out_res, 32'h0000_0001);
    issue(1'b0, 32'hFFFF_FFFF, 32'h4000_0000);
    check("R2 neg half", out_res, 32'h0000_0000);
    // R3: most negative squared
    issue(1'b0, 32'h8000_0000, 32'h8000_0000);
    check("R3 res", out_res, 32'h7FFF_FFFF);
    check("R3 ovf", {31'b0, out_ovf}, 32'h1);
    // R4: narrow range, both bounds
    issue(1'b0, 32'h4000_0000, 32'h4000_0000);
    check("R4 narrow hi", n_out_res, 32'h0007_FFFF);
    check("R4 narrow hi ovf", {31'b0, n_out_ovf}, 32'h1);
    check("R4 full no ovf", {31'b0, out_ovf}, 32'h0);
    issue(1'b0, 32'hC000_0000, 32'h4000_0000);
    check("R4 narrow lo", n_out_res, 32'hFFF8_0000);
    // R5: upper bits ignored, sign extension
    issue(1'b1, 32'hFFFF_4000, 32'h8000_4000);
    check("R5 quarter", out_res, 32'h0000_2000);
    issue(1'b1, 32'h1234_8000, 32'h0000_4000);
    check("R5 neg half", out_res, 32'hFFFF_C000);
    // R6: -1 x -1 in Q15
    issue(1'b1, 32'h0000_8000, 32'h0000_8000);
    check("R6 res", out_res, 32'h0000_7FFF);
    check("R6 ovf", {31'b0, out_ovf}, 32'h1);

    // R8: backpressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_q15 = 1'b0; in_a = 32'h0000_4000; in_b = 32'h4000_0000;
    @(negedge clk);
    check("R8 in_ready low", {31'b0, in_ready}, 32'h0);
    in_a = 32'h0000_C000; in_b = 32'h2000_0000;
    @(negedge clk);
    check("R8 held res", out_res, 32'h0000_2000);
    check("R8 held valid", {31'b0, out_valid}, 32'h1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next accepted", out_res, 32'h0000_3000);
    @(negedge clk);
    check("R7 drained", {31'b0, out_valid}, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule